// File: doc/BRIEF.md
# PC Card Byte/Word Lane Steering Controller

This block is the card-side decode and steering logic of a removable memory card with a 16-bit host connector. Each clock it samples the host strobes: two active-low byte enables (even and odd), the address (including bit 0), output enable, write enable and the attribute-plane select. From these it decides which byte lanes take part in the access and which memory is addressed. Host data is routed to or from an array of byte-wide memory devices organised in low/high pairs, or to or from a byte-wide attribute memory that holds only even bytes.

For array accesses the block generates one-hot low-byte and high-byte chip selects from the upper address bits. It applies a wrap at the next power of two above the populated pair count, so a card with three pairs wraps every four pair slots. It also produces the array read and write strobes, with writes held off while the write-protect input is high. On the host side it returns steered read data together with a per-lane drive enable, which the pad ring uses as the tri-state control. The wait output and both battery-status outputs are tied high, so the host never sees a wait state.

Timing is synchronous. Array and attribute side outputs are registered one clock after the host inputs are sampled. Host read data and lane enables are registered one clock later, capturing the memory's combinational read data.

Top module: `pccard_lane_steer`

## Requirements
- R1: With both byte enables high (standby), no array or attribute strobe or chip select is raised and both host lane enables stay low, whatever the other inputs are.
- R2: Even enable low, odd enable high, A0 low: only the low lane is driven, and it carries the even byte (device low half). A write goes to the low-byte select only.
- R3: Even enable low, odd enable high, A0 high: the odd byte travels on the low lane. A read returns the high-byte device data on host bits 7..0. A write places host bits 7..0 on array data bits 15..8 and raises only the high-byte select.
- R4: Both enables low: word access. The odd byte is on host bits 15..8, the even byte on bits 7..0, both lanes are driven, and A0 has no effect.
- R5: Odd enable low, even enable high: odd-byte-only access on host bits 15..8. The low lane is not driven, and a write changes only the high-byte device.
- R6: Attribute select low routes the access to the attribute memory and keeps every array chip select low. The even byte uses host bits 7..0. Odd-byte read positions return 8'h00. A write that carries no even byte raises no attribute write strobe.
- R7: A read needs output enable low and write enable high. A write needs write enable low and output enable high. Both low, or both high, starts no access.
- R8: The array word address is host address bits DEV_AW..1. The pair index is the address bits above that. Chip selects are one-hot, with bit p selecting pair p.
- R9: The pair index is taken modulo the smallest power of two that is at least cfg_pairs. An index that is still at or above cfg_pairs raises no chip select.
- R10: While wp_in is high, array_wr stays low. Attribute writes are unaffected.
- R11: host_wait_n, host_bstat1 and host_bstat2 are high at all times, including during reset.
- R12: Array and attribute side outputs change one clock after the host inputs are sampled. Host read data and lane enables change two clocks after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_even_en_n | input | 1 | Even-byte card enable, active low |
| host_odd_en_n | input | 1 | Odd-byte card enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_attr_sel_n | input | 1 | Attribute plane select, active low |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Steered read data to host |
| host_lo_oe | output | 1 | Drive enable for host bits 7..0 |
| host_hi_oe | output | 1 | Drive enable for host bits 15..8 |
| host_wait_n | output | 1 | Wait indication, always high |
| host_bstat1 | output | 1 | Battery status 1, always high |
| host_bstat2 | output | 1 | Battery status 2, always high |
| wp_in | input | 1 | Write-protect switch, high blocks array writes |
| cfg_pairs | input | CNT_W | Populated device pair count |
| array_addr | output | DEV_AW | Word address inside a device |
| array_cs_lo | output | MAX_PAIRS | Low-byte device selects, one-hot |
| array_cs_hi | output | MAX_PAIRS | High-byte device selects, one-hot |
| array_rd | output | 1 | Array read strobe |
| array_wr | output | 1 | Array write strobe |
| array_wdata | output | 16 | Array write data, high device on 15..8 |
| array_rdata | input | 16 | Array read data, high device on 15..8 |
| attr_addr | output | ATTR_AW | Attribute memory byte index |
| attr_cs | output | 1 | Attribute memory select |
| attr_rd | output | 1 | Attribute read strobe |
| attr_wr | output | 1 | Attribute write strobe |
| attr_wdata | output | 8 | Attribute write data |
| attr_rdata | input | 8 | Attribute read data |

## Verification
A wrong decode of the lane mode appears one clock after the strobes as a select on the wrong half of a pair. It appears again on the following clock as a lane enable or byte that lands in the wrong position, so each scenario writes through one mode and reads back through another. A corrupt pair index or wrap mask shows at once as a chip select on the wrong bit or no select at all. It then reappears as stale data from an aliased address on the next read-back. A lost write-protect or attribute guard leaves memory contents changed, and that is only visible on a later read of the same location.

// File: rtl/pcls_pkg.sv
package pcls_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_BYTE_EVEN = 3'd1,
    MODE_BYTE_ODD  = 3'd2,
    MODE_WORD      = 3'd3,
    MODE_ODD_ONLY  = 3'd4
  } lane_mode_e;

  typedef struct packed {
    lane_mode_e mode;
    logic       is_rd;
    logic       is_wr;
    logic       attr;
    logic       en_even;
    logic       en_odd;
  } access_t;

endpackage

// File: rtl/pcls_decode.sv
module pcls_decode
  import pcls_pkg::*;
(
  input  logic    even_en_n,
  input  logic    odd_en_n,
  input  logic    a0,
  input  logic    oe_n,
  input  logic    we_n,
  input  logic    attr_sel_n,
  output access_t acc
);

  logic rd_q;
  logic wr_q;
  lane_mode_e mode;

  assign rd_q = !oe_n && we_n;
  assign wr_q = !we_n && oe_n;

  always_comb begin
    mode = MODE_IDLE;
    if (rd_q || wr_q) begin
      unique case ({even_en_n, odd_en_n})
        2'b01:   mode = a0 ? MODE_BYTE_ODD : MODE_BYTE_EVEN;
        2'b00:   mode = MODE_WORD;
        2'b10:   mode = MODE_ODD_ONLY;
        default: mode = MODE_IDLE;
      endcase
    end
  end

  always_comb begin
    acc.mode    = mode;
    acc.is_rd   = rd_q && (mode != MODE_IDLE);
    acc.is_wr   = wr_q && (mode != MODE_IDLE);
    acc.attr    = !attr_sel_n;
    acc.en_even = (mode == MODE_BYTE_EVEN) || (mode == MODE_WORD);
    acc.en_odd  = (mode == MODE_BYTE_ODD) || (mode == MODE_WORD) ||
                  (mode == MODE_ODD_ONLY);
  end

endmodule

// File: rtl/pcls_chipsel.sv
module pcls_chipsel #(
  parameter int IDX_W     = 4,
  parameter int MAX_PAIRS = 10,
  parameter int CNT_W     = 4
) (
  input  logic [IDX_W-1:0]     idx_raw,
  input  logic [CNT_W-1:0]     cfg_pairs,
  input  logic                 sel_lo,
  input  logic                 sel_hi,
  output logic [MAX_PAIRS-1:0] cs_lo,
  output logic [MAX_PAIRS-1:0] cs_hi
);

  localparam int CMP_W = (IDX_W > CNT_W) ? IDX_W + 1 : CNT_W + 1;

  function automatic logic [IDX_W-1:0] smear_down(input logic [IDX_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = v;
    for (int s = 1; s < IDX_W; s = s * 2) begin
      r = r | (r >> s);
    end
    return r;
  endfunction

  logic [IDX_W-1:0] pairs_m1;
  logic [IDX_W-1:0] wrap_mask;
  logic [IDX_W-1:0] idx;
  logic             in_range;

  assign pairs_m1  = IDX_W'(cfg_pairs) - IDX_W'(1);
  assign wrap_mask = smear_down(pairs_m1);
  assign idx       = idx_raw & wrap_mask;
  assign in_range  = CMP_W'(idx) < CMP_W'(cfg_pairs);

  for (genvar p = 0; p < MAX_PAIRS; p++) begin : g_pair
    logic hit;
    assign hit      = in_range && (idx == IDX_W'(p));
    assign cs_lo[p] = hit && sel_lo;
    assign cs_hi[p] = hit && sel_hi;
  end

endmodule

// File: rtl/pcls_rsteer.sv
module pcls_rsteer
  import pcls_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lane_mode_e  s1_mode,
  input  logic        s1_rd,
  input  logic        s1_attr,
  input  logic [15:0] array_rdata,
  input  logic [7:0]  attr_rdata,
  output logic [15:0] host_rdata,
  output logic        lo_oe,
  output logic        hi_oe
);

  logic [7:0] even_src;
  logic [7:0] odd_src;

  assign even_src = s1_attr ? attr_rdata : array_rdata[7:0];
  assign odd_src  = s1_attr ? 8'h00      : array_rdata[15:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      lo_oe      <= 1'b0;
      hi_oe      <= 1'b0;
    end else begin
      host_rdata <= '0;
      lo_oe      <= 1'b0;
      hi_oe      <= 1'b0;
      if (s1_rd) begin
        unique case (s1_mode)
          MODE_BYTE_EVEN: begin
            lo_oe            <= 1'b1;
            host_rdata[7:0]  <= even_src;
          end
          MODE_BYTE_ODD: begin
            lo_oe            <= 1'b1;
            host_rdata[7:0]  <= odd_src;
          end
          MODE_WORD: begin
            lo_oe            <= 1'b1;
            hi_oe            <= 1'b1;
            host_rdata       <= {odd_src, even_src};
          end
          MODE_ODD_ONLY: begin
            hi_oe            <= 1'b1;
            host_rdata[15:8] <= odd_src;
          end
          default: begin
            lo_oe <= 1'b0;
          end
        endcase
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (s1_mode == MODE_IDLE) |=> (!lo_oe && !hi_oe));

  assert_lane_latency_R12: assert property (@(posedge clk) disable iff (rst)
    (lo_oe || hi_oe) |-> $past(s1_rd));

endmodule

// File: rtl/pccard_lane_steer.sv
module pccard_lane_steer
  import pcls_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DEV_AW    = 17,
  parameter int MAX_PAIRS = 10,
  parameter int CNT_W     = 4,
  parameter int ATTR_AW   = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_even_en_n,
  input  logic                 host_odd_en_n,
  input  logic                 host_oe_n,
  input  logic                 host_we_n,
  input  logic                 host_attr_sel_n,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [15:0]          host_wdata,
  output logic [15:0]          host_rdata,
  output logic                 host_lo_oe,
  output logic                 host_hi_oe,
  output logic                 host_wait_n,
  output logic                 host_bstat1,
  output logic                 host_bstat2,
  input  logic                 wp_in,
  input  logic [CNT_W-1:0]     cfg_pairs,
  output logic [DEV_AW-1:0]    array_addr,
  output logic [MAX_PAIRS-1:0] array_cs_lo,
  output logic [MAX_PAIRS-1:0] array_cs_hi,
  output logic                 array_rd,
  output logic                 array_wr,
  output logic [15:0]          array_wdata,
  input  logic [15:0]          array_rdata,
  output logic [ATTR_AW-1:0]   attr_addr,
  output logic                 attr_cs,
  output logic                 attr_rd,
  output logic                 attr_wr,
  output logic [7:0]           attr_wdata,
  input  logic [7:0]           attr_rdata
);

  localparam int IDX_W = ADDR_W - DEV_AW - 1;

  access_t              acc;
  logic [MAX_PAIRS-1:0] cs_lo_d;
  logic [MAX_PAIRS-1:0] cs_hi_d;
  logic                 arr_go;
  logic                 attr_go;
  lane_mode_e           s1_mode;
  logic                 s1_rd;
  logic                 s1_attr;

  assign host_wait_n = 1'b1;
  assign host_bstat1 = 1'b1;
  assign host_bstat2 = 1'b1;

  pcls_decode u_decode (
    .even_en_n  (host_even_en_n),
    .odd_en_n   (host_odd_en_n),
    .a0         (host_addr[0]),
    .oe_n       (host_oe_n),
    .we_n       (host_we_n),
    .attr_sel_n (host_attr_sel_n),
    .acc        (acc)
  );

  assign arr_go  = !acc.attr && (acc.is_rd || acc.is_wr);
  assign attr_go =  acc.attr && (acc.is_rd || acc.is_wr);

  pcls_chipsel #(
    .IDX_W     (IDX_W),
    .MAX_PAIRS (MAX_PAIRS),
    .CNT_W     (CNT_W)
  ) u_chipsel (
    .idx_raw   (host_addr[ADDR_W-1:DEV_AW+1]),
    .cfg_pairs (cfg_pairs),
    .sel_lo    (arr_go && acc.en_even),
    .sel_hi    (arr_go && acc.en_odd),
    .cs_lo     (cs_lo_d),
    .cs_hi     (cs_hi_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      array_addr  <= '0;
      array_cs_lo <= '0;
      array_cs_hi <= '0;
      array_rd    <= 1'b0;
      array_wr    <= 1'b0;
      array_wdata <= '0;
      attr_addr   <= '0;
      attr_cs     <= 1'b0;
      attr_rd     <= 1'b0;
      attr_wr     <= 1'b0;
      attr_wdata  <= '0;
      s1_mode     <= MODE_IDLE;
      s1_rd       <= 1'b0;
      s1_attr     <= 1'b0;
    end else begin
      array_addr  <= host_addr[DEV_AW:1];
      array_cs_lo <= cs_lo_d;
      array_cs_hi <= cs_hi_d;
      array_rd    <= arr_go && acc.is_rd;
      array_wr    <= arr_go && acc.is_wr && !wp_in;
      array_wdata <= {(acc.mode == MODE_BYTE_ODD) ? host_wdata[7:0] : host_wdata[15:8],
                      host_wdata[7:0]};
      attr_addr   <= host_addr[ATTR_AW:1];
      attr_cs     <= attr_go;
      attr_rd     <= attr_go && acc.is_rd;
      attr_wr     <= attr_go && acc.is_wr && acc.en_even;
      attr_wdata  <= host_wdata[7:0];
      s1_mode     <= acc.mode;
      s1_rd       <= acc.is_rd;
      s1_attr     <= acc.attr;
    end
  end

  pcls_rsteer u_rsteer (
    .clk         (clk),
    .rst         (rst),
    .s1_mode     (s1_mode),
    .s1_rd       (s1_rd),
    .s1_attr     (s1_attr),
    .array_rdata (array_rdata),
    .attr_rdata  (attr_rdata),
    .host_rdata  (host_rdata),
    .lo_oe       (host_lo_oe),
    .hi_oe       (host_hi_oe)
  );

  assert_standby_R1: assert property (@(posedge clk) disable iff (rst)
    (host_even_en_n && host_odd_en_n) |=> (!array_rd && !array_wr && !attr_cs));

  assert_attr_excl_R6: assert property (@(posedge clk) disable iff (rst)
    attr_cs |-> (array_cs_lo == '0 && array_cs_hi == '0));

  assert_no_clash_R7: assert property (@(posedge clk) disable iff (rst)
    !(array_rd && array_wr));

  assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(array_cs_lo) && $onehot0(array_cs_hi));

  assert_wp_block_R10: assert property (@(posedge clk) disable iff (rst)
    wp_in |=> !array_wr);

endmodule

// File: tb/pccard_lane_steer_test.sv
`timescale 1ns/1ps
module pccard_lane_steer_test;

  localparam int ADDR_W = 9;
  localparam int DEV_AW = 4;
  localparam int NP     = 10;
  localparam int CNT_W  = 4;
  localparam int ATTR_AW = 4;

  logic clk = 1'b0;
  logic rst;
  logic ev_n, od_n, oe_n, we_n, at_n, wp;
  logic [ADDR_W-1:0] addr;
  logic [15:0] wdata;
  logic [CNT_W-1:0] cfg;
  logic [15:0] hrd;
  logic lo_oe, hi_oe, wait_n, bs1, bs2;
  logic [DEV_AW-1:0] a_addr;
  logic [NP-1:0] cs_lo, cs_hi;
  logic a_rd, a_wr;
  logic [15:0] a_wd, a_rdd;
  logic [ATTR_AW-1:0] t_addr;
  logic t_cs, t_rd, t_wr;
  logic [7:0] t_wd, t_rdd;

  logic [7:0] mlo [NP][16];
  logic [7:0] mhi [NP][16];
  logic [7:0] amem [16];

  int n_tests = 0;
  int n_fail  = 0;

  logic [NP-1:0] c_cs_lo, c_cs_hi;
  logic c_rd, c_wr, c_twr, c_mid_oe;
  logic [DEV_AW-1:0] c_addr;
  logic [15:0] c_wd, c_rdata;
  logic c_lo, c_hi;

  always #2 clk = ~clk;

  pccard_lane_steer #(
    .ADDR_W(ADDR_W), .DEV_AW(DEV_AW), .MAX_PAIRS(NP), .CNT_W(CNT_W), .ATTR_AW(ATTR_AW)
  ) uut (
    .clk(clk), .rst(rst),
    .host_even_en_n(ev_n), .host_odd_en_n(od_n), .host_oe_n(oe_n), .host_we_n(we_n),
    .host_attr_sel_n(at_n), .host_addr(addr), .host_wdata(wdata),
    .host_rdata(hrd), .host_lo_oe(lo_oe), .host_hi_oe(hi_oe),
    .host_wait_n(wait_n), .host_bstat1(bs1), .host_bstat2(bs2),
    .wp_in(wp), .cfg_pairs(cfg),
    .array_addr(a_addr), .array_cs_lo(cs_lo), .array_cs_hi(cs_hi),
    .array_rd(a_rd), .array_wr(a_wr), .array_wdata(a_wd), .array_rdata(a_rdd),
    .attr_addr(t_addr), .attr_cs(t_cs), .attr_rd(t_rd), .attr_wr(t_wr),
    .attr_wdata(t_wd), .attr_rdata(t_rdd)
  );

  always_comb begin
    a_rdd = 16'h0000;
    for (int p = 0; p < NP; p++) begin
      if (cs_lo[p]) a_rdd[7:0]  = mlo[p][a_addr];
      if (cs_hi[p]) a_rdd[15:8] = mhi[p][a_addr];
    end
    t_rdd = t_cs ? amem[t_addr] : 8'h00;
  end

  always @(posedge clk) begin
    if (a_wr) begin
      for (int p = 0; p < NP; p++) begin
        if (cs_lo[p]) mlo[p][a_addr] <= a_wd[7:0];
        if (cs_hi[p]) mhi[p][a_addr] <= a_wd[15:8];
      end
    end
    if (t_wr) amem[t_addr] <= t_wd;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    ev_n = 1'b1; od_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; at_n = 1'b1;
  endtask

  // One host access: strobes held for one clock, then idle; captures
  // the array side one clock later and the host side two clocks later.
  task automatic cycle(input logic e, input logic o, input logic r, input logic oe,
                       input logic we, input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    ev_n = e; od_n = o; at_n = r; oe_n = oe; we_n = we; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    c_cs_lo = cs_lo; c_cs_hi = cs_hi; c_rd = a_rd; c_wr = a_wr; c_twr = t_wr;
    c_addr = a_addr; c_wd = a_wd; c_mid_oe = lo_oe | hi_oe;
    go_idle();
    @(posedge clk);
    @(negedge clk);
    c_rdata = hrd; c_lo = lo_oe; c_hi = hi_oe;
  endtask

  task automatic wr(input logic e, input logic o, input logic r,
                    input logic [ADDR_W-1:0] a, input logic [15:0] d);
    cycle(e, o, r, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic e, input logic o, input logic r, input logic [ADDR_W-1:0] a);
    cycle(e, o, r, 1'b0, 1'b1, a, 16'h0000);
  endtask

  task automatic test_reset();
    chk("R1 reset lanes", {lo_oe, hi_oe}, 0);
    chk("R1 reset strobes", {a_rd, a_wr, t_cs, cs_lo, cs_hi}, 0);
    chk("R11 fixed outputs", {wait_n, bs1, bs2}, 3'b111);
  endtask

  task automatic test_standby();
    cycle(1, 1, 1, 1'b1, 1'b0, 9'h006, 16'hFFFF);
    chk("R1 standby write", {c_wr, c_twr, c_cs_lo, c_cs_hi}, 0);
    cycle(1, 1, 0, 1'b0, 1'b1, 9'h006, 16'h0000);
    chk("R1 standby read lanes", {c_lo, c_hi, c_rdata}, 0);
    chk("R11 fixed outputs busy", {wait_n, bs1, bs2}, 3'b111);
  endtask

  task automatic test_word();
    wr(0, 0, 1, 9'h006, 16'hA55A);
    chk("R8 word write selects", {c_cs_hi, c_cs_lo}, {10'h001, 10'h001});
    chk("R8 array address", c_addr, 3);
    chk("R4 word write strobe", c_wr, 1);
    rd(0, 0, 1, 9'h006);
    chk("R4 word read data", c_rdata, 16'hA55A);
    chk("R4 word lanes", {c_lo, c_hi}, 2'b11);
    chk("R12 host lane one clock after", c_mid_oe, 0);
    rd(0, 0, 1, 9'h007);
    chk("R4 A0 ignored", c_rdata, 16'hA55A);
  endtask

  task automatic test_byte();
    wr(0, 1, 1, 9'h022, 16'h0011);
    chk("R2 even write selects", {c_cs_hi, c_cs_lo}, {10'h000, 10'h002});
    wr(0, 1, 1, 9'h023, 16'h0022);
    chk("R3 odd write selects", {c_cs_hi, c_cs_lo}, {10'h002, 10'h000});
    chk("R3 odd write data lane", c_wd[15:8], 8'h22);
    rd(0, 0, 1, 9'h022);
    chk("R3 word readback of byte writes", c_rdata, 16'h2211);
    rd(0, 1, 1, 9'h022);
    chk("R2 even byte read", {c_lo, c_hi, c_rdata}, {2'b10, 16'h0011});
    rd(0, 1, 1, 9'h023);
    chk("R3 odd byte on low lane", {c_lo, c_hi, c_rdata}, {2'b10, 16'h0022});
  endtask

  task automatic test_oddonly();
    wr(0, 0, 1, 9'h040, 16'h1234);
    wr(1, 0, 1, 9'h040, 16'h7700);
    chk("R5 odd-only write selects", {c_cs_hi, c_cs_lo}, {10'h004, 10'h000});
    rd(0, 0, 1, 9'h040);
    chk("R5 even byte untouched", c_rdata, 16'h7734);
    rd(1, 0, 1, 9'h040);
    chk("R5 odd-only read", {c_lo, c_hi, c_rdata[15:8]}, {2'b01, 8'h77});
  endtask

  task automatic test_attr();
    wr(0, 0, 0, 9'h004, 16'hBEEF);
    chk("R6 attr write strobe", c_twr, 1);
    chk("R6 no array select", {c_wr, c_cs_lo, c_cs_hi}, 0);
    rd(0, 1, 0, 9'h004);
    chk("R6 attr even read", {c_lo, c_rdata}, {1'b1, 16'h00EF});
    rd(0, 1, 0, 9'h005);
    chk("R6 attr odd read zero", {c_lo, c_rdata}, {1'b1, 16'h0000});
    wr(1, 0, 0, 9'h005, 16'h9900);
    chk("R6 attr odd write ignored", c_twr, 0);
    rd(0, 0, 0, 9'h004);
    chk("R6 attr word read", {c_lo, c_hi, c_rdata}, {2'b11, 16'h00EF});
  endtask

  task automatic test_qualify();
    cycle(0, 0, 1, 1'b0, 1'b0, 9'h006, 16'hFFFF);
    chk("R7 both strobes low no access", {c_rd, c_wr, c_lo, c_hi}, 0);
    cycle(0, 0, 1, 1'b1, 1'b1, 9'h006, 16'hFFFF);
    chk("R7 both strobes high no access", {c_rd, c_wr, c_lo, c_hi}, 0);
    rd(0, 0, 1, 9'h006);
    chk("R7 data unchanged", c_rdata, 16'hA55A);
  endtask

  task automatic test_wp();
    wp = 1'b1;
    wr(0, 0, 1, 9'h006, 16'h0000);
    chk("R10 protected write strobe", c_wr, 0);
    rd(0, 0, 1, 9'h006);
    chk("R10 protected data kept", c_rdata, 16'hA55A);
    wr(0, 1, 0, 9'h008, 16'h0042);
    chk("R10 attr write still allowed", c_twr, 1);
    rd(0, 1, 0, 9'h008);
    chk("R10 attr readback", c_rdata, 16'h0042);
    wp = 1'b0;
  endtask

  task automatic test_wrap();
    cfg = 4'd3;
    wr(0, 0, 1, 9'h0A2, 16'h5A5A);
    chk("R9 pair 5 aliases pair 1", c_cs_lo, 10'h002);
    rd(0, 0, 1, 9'h022);
    chk("R9 alias readback", c_rdata, 16'h5A5A);
    wr(0, 0, 1, 9'h062, 16'h0101);
    chk("R9 unpopulated pair no select", {c_cs_lo, c_cs_hi}, 0);
    cfg = 4'd10;
    wr(0, 0, 1, 9'h180, 16'h0202);
    chk("R9 index 12 beyond ten pairs", {c_cs_lo, c_cs_hi}, 0);
    wr(0, 0, 1, 9'h122, 16'hC3C3);
    chk("R8 pair 9 select", c_cs_hi, 10'h200);
    rd(0, 0, 1, 9'h122);
    chk("R8 pair 9 readback", c_rdata, 16'hC3C3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    go_idle();
    addr = '0; wdata = '0; wp = 1'b0; cfg = 4'd10;
    rst = 1'b1;
    chk("R11 fixed outputs in reset", {wait_n, bs1, bs2}, 3'b111);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_standby();
    test_word();
    test_byte();
    test_oddonly();
    test_attr();
    test_qualify();
    test_wp();
    test_wrap();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule